// File: doc/BRIEF.md
# Direct-Mapped Decoded-Instruction Cache

This block keeps already-decoded instruction records next to the fetch path. A fetch looks up a word-aligned 64-bit instruction address in the same cycle. The block returns a hit flag and the stored decoded record. On a miss, the decoder writes the record and its address through the fill port, so the next fetch of that address skips decoding.

Each entry stores the full instruction address as its tag and has no separate valid bit. An entry is invalid when its tag is all ones, a value that no word-aligned address can equal. A flush request or a context-synchronize request starts a walk. The walk overwrites one entry per clock with the all-ones tag and raises `busy` for its whole length. The same walk runs on its own after reset. The number of entries must be a power of two, so the index is simply a group of low address bits above the byte offset.

Top module: `decoded_insn_cache`

## Requirements
- R1: The entry used by an address is (address / 4) mod ENTRIES, that is, address bits [log2(ENTRIES)+1:2]. Two addresses that differ by a multiple of 4*ENTRIES share one entry, and the later fill evicts the earlier one.
- R2: `lk_hit` is 1 only when the tag stored at the indexed entry equals all 64 bits of `lk_addr`. While `lk_hit` is 1, `lk_data` is the payload stored with that tag.
- R3: When `fill_en` is 1, `busy` is 0 and neither flush request is 1, the next clock edge stores `fill_addr` as the tag and `fill_data` as the payload of the entry that `fill_addr` indexes. A lookup of that address hits from the following cycle.
- R4: A cycle with `flush_req` at 1 makes `busy` 1 from the next cycle for exactly ENTRIES cycles. After the walk, no word-aligned address hits.
- R5: `ctx_sync_req` has exactly the effect of `flush_req`: the same walk, the same length and every entry invalid afterwards.
- R6: While `busy` is 1, every lookup reports `lk_hit` = 0, even for an address that was filled before the flush.
- R7: A fill in the same cycle as a flush request is dropped, and so is a fill while `busy` is 1. A lookup of such an address misses after the walk.
- R8: While reset is held, and for ENTRIES cycles after it is released, `busy` is 1. After that, no word-aligned address hits.
- R9: A flush request while a walk is running restarts the walk at entry 0. `busy` then stays 1 for ENTRIES cycles counted from the new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_addr | input | ADDR_W | Lookup address, word aligned |
| lk_hit | output | 1 | Lookup hit |
| lk_data | output | PAYLOAD_W | Decoded record of the indexed entry |
| fill_en | input | 1 | Write an entry |
| fill_addr | input | ADDR_W | Address stored as the tag |
| fill_data | input | PAYLOAD_W | Decoded record to store |
| flush_req | input | 1 | Invalidate every entry |
| ctx_sync_req | input | 1 | Context synchronize, which also flushes everything |
| busy | output | 1 | Invalidation walk in progress |

## Verification
A wrong internal state shows up at the lookup port in different ways:
- A wrong index or tag shows up as a false hit, or as a lost hit, in the first lookup after the fill. The sweep over every entry, with aliases and addresses that differ only in high bits, exposes it.
- A walk counter that stops early or restarts badly shows up on `busy` within ENTRIES cycles of the request. It also shows up as a stale hit just after `busy` falls.
- A fill that slips past a flush becomes a hit as soon as the walk ends.

// File: rtl/decoded_insn_cache.sv
`timescale 1ns/1ps
module decoded_insn_cache #(
  parameter int ENTRIES   = 8,
  parameter int PAYLOAD_W = 24,
  parameter int ADDR_W    = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    lk_addr,
  output logic                 lk_hit,
  output logic [PAYLOAD_W-1:0] lk_data,
  input  logic                 fill_en,
  input  logic [ADDR_W-1:0]    fill_addr,
  input  logic [PAYLOAD_W-1:0] fill_data,
  input  logic                 flush_req,
  input  logic                 ctx_sync_req,
  output logic                 busy
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ADDR_W-1:0]    tag_q [ENTRIES];
  logic [PAYLOAD_W-1:0] pay_q [ENTRIES];
  logic [IDX_W-1:0]     walk_q;
  logic                 busy_q;

  wire              flush_any = flush_req | ctx_sync_req;
  wire [IDX_W-1:0]  lk_idx    = lk_addr[IDX_W+1:2];
  wire [IDX_W-1:0]  fill_idx  = fill_addr[IDX_W+1:2];
  wire              fill_ok   = fill_en & ~busy_q & ~flush_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      walk_q <= '0;
    end else if (flush_any) begin
      busy_q <= 1'b1;
      walk_q <= '0;
    end else if (busy_q) begin
      if (walk_q == LAST) busy_q <= 1'b0;
      walk_q <= walk_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (busy_q) begin
      tag_q[walk_q] <= '1;
    end else if (fill_ok) begin
      tag_q[fill_idx] <= fill_addr;
      pay_q[fill_idx] <= fill_data;
    end
  end

  assign lk_hit  = ~busy_q & (tag_q[lk_idx] == lk_addr);
  assign lk_data = pay_q[lk_idx];
  assign busy    = busy_q;

  assert_flush_enters_walk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> busy_q && walk_q == '0);

  assert_sync_enters_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_sync_req |=> busy_q && walk_q == '0);

  assert_walk_one_per_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !flush_any && walk_q != LAST) |=> busy_q && walk_q == IDX_W'($past(walk_q) + 1'b1));

  assert_fill_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !busy_q && !flush_any) |=> tag_q[$past(fill_idx)] == $past(fill_addr));

  assert_fill_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && flush_any && !busy_q) |=> tag_q[$past(fill_idx)] == $past(tag_q[fill_idx]));

  assert_clean_after_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && lk_addr[1:0] == 2'b00) |-> !lk_hit);
endmodule

// File: tb/decoded_insn_cache_tb_top.sv
`timescale 1ns/1ps
module decoded_insn_cache_tb_top;
  localparam int N  = 8;
  localparam int PW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [63:0]   lk_addr = '0;
  logic          lk_hit;
  logic [PW-1:0] lk_data;
  logic          fill_en = 1'b0;
  logic [63:0]   fill_addr = '0;
  logic [PW-1:0] fill_data = '0;
  logic          flush_req = 1'b0;
  logic          ctx_sync_req = 1'b0;
  logic          busy;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [63:0]   mt [N];
  logic [PW-1:0] md [N];

  always #2 clk = ~clk;

  decoded_insn_cache #(.ENTRIES(N), .PAYLOAD_W(PW), .ADDR_W(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
    .flush_req(flush_req), .ctx_sync_req(ctx_sync_req), .busy(busy));

  function automatic int idx_of(logic [63:0] a);
    return int'((a >> 2) % N);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic model_flush;
    for (int i = 0; i < N; i++) mt[i] = '1;
  endtask

  task automatic do_fill(logic [63:0] a, logic [PW-1:0] d);
    fill_en = 1'b1; fill_addr = a; fill_data = d;
    tick;
    fill_en = 1'b0;
    mt[idx_of(a)] = a;
    md[idx_of(a)] = d;
  endtask

  task automatic look(string req, logic [63:0] a);
    logic exp_hit;
    lk_addr = a;
    #0.2;
    exp_hit = (mt[idx_of(a)] == a);
    chk(req, {63'd0, lk_hit}, {63'd0, exp_hit});
    if (exp_hit) chk(req, {40'd0, lk_data}, {40'd0, md[idx_of(a)]});
  endtask

  task automatic wait_walk(string req);
    for (int i = 0; i < N; i++) begin
      chk(req, {63'd0, busy}, 64'd1);
      tick;
    end
    chk(req, {63'd0, busy}, 64'd0);
  endtask

  task automatic pulse_flush(bit sync);
    if (sync) ctx_sync_req = 1'b1; else flush_req = 1'b1;
    tick;
    ctx_sync_req = 1'b0; flush_req = 1'b0;
    model_flush();
  endtask

  task automatic fill_all(logic [63:0] base, int salt);
    for (int i = 0; i < N; i++) do_fill(base + 64'(i * 4), PW'(i * 37 + salt));
  endtask

  localparam logic [63:0] BASE = 64'h0000_1000_0000_0000;

  initial begin
    model_flush();
    for (int i = 0; i < N; i++) md[i] = '0;
    tick; tick;
    chk("R8 busy in reset", {63'd0, busy}, 64'd1);
    chk("R8 miss in reset", {63'd0, lk_hit}, 64'd0);
    rst_n = 1'b1;
    wait_walk("R8 walk after reset");
    for (int i = 0; i < 2 * N; i++) look("R8 clean after reset", 64'(i * 4));

    fill_all(BASE, 5);
    for (int i = 0; i < N; i++) begin
      look("R3 hit after fill", BASE + 64'(i * 4));
      look("R2 high bit differs", (BASE + 64'(i * 4)) ^ (64'd1 << 40));
      look("R2 top bit differs", (BASE + 64'(i * 4)) ^ (64'd1 << 63));
      look("R1 alias misses", BASE + 64'(i * 4) + 64'(N * 4));
    end

    do_fill(BASE + 64'(N * 4), 24'h5A5A5A);
    look("R1 alias evicts old", BASE);
    look("R1 alias hits new", BASE + 64'(N * 4));
    for (int i = 1; i < N; i++) look("R1 other entries kept", BASE + 64'(i * 4));
    for (int k = 0; k < 4 * N; k++) look("R1 index sweep", BASE + 64'(k * 4));

    fill_en = 1'b1; fill_addr = BASE + 64'h40_0000 + 12; fill_data = 24'h123456;
    flush_req = 1'b1;
    tick;
    fill_en = 1'b0; flush_req = 1'b0;
    model_flush();
    wait_walk("R4 walk length");
    look("R7 fill with flush dropped", BASE + 64'h40_0000 + 12);
    for (int i = 0; i < N; i++) look("R4 all invalid", BASE + 64'(i * 4));

    fill_all(BASE + 64'h8000, 11);
    pulse_flush(1'b0);
    for (int i = 0; i < N; i++) begin
      chk("R6 busy during walk", {63'd0, busy}, 64'd1);
      fill_en = 1'b1; fill_addr = 64'h2000 + 64'(i * 4); fill_data = PW'(i + 1);
      lk_addr = BASE + 64'h8000 + 64'(i * 4);
      #0.2;
      chk("R6 miss while busy", {63'd0, lk_hit}, 64'd0);
      tick;
    end
    fill_en = 1'b0;
    chk("R6 walk done", {63'd0, busy}, 64'd0);
    for (int i = 0; i < N; i++) look("R7 fill during busy dropped", 64'h2000 + 64'(i * 4));

    fill_all(BASE + 64'h2_0000, 17);
    for (int i = 0; i < N; i++) look("R3 refill hits", BASE + 64'h2_0000 + 64'(i * 4));
    pulse_flush(1'b1);
    wait_walk("R5 sync walk length");
    for (int i = 0; i < N; i++) look("R5 sync invalidates", BASE + 64'h2_0000 + 64'(i * 4));

    fill_all(BASE + 64'h3_0000, 23);
    pulse_flush(1'b0);
    tick; tick; tick;
    chk("R9 busy mid walk", {63'd0, busy}, 64'd1);
    pulse_flush(1'b0);
    wait_walk("R9 restarted walk length");
    for (int i = 0; i < N; i++) look("R9 invalid after restart", BASE + 64'h3_0000 + 64'(i * 4));

    do_fill(64'h0000_0000_FFFF_FFFC, 24'hC0FFEE);
    look("R3 fill after walks", 64'h0000_0000_FFFF_FFFC);
    look("R2 upper word differs", 64'hFFFF_FFFF_FFFF_FFFC);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule